// File: doc/BRIEF.md
# Peripheral Run-State and Status Controller

This block is the control and status front end of a serial peripheral core. It keeps the core's operating state (reset, running or paused) together with a valid indication. The valid indication drops while a state change settles. The block also provides a soft-reset command, sticky error and master status fields that software clears by writing ones, and two FIFO service flags. A protocol engine and its FIFOs sit outside the block. They feed it event pulses and FIFO level signals, and the block drives back a run enable and the service and error indications.

Software uses a simple register port: a single-cycle write strobe with address and data, and a read data bus that follows the address combinationally. The state machine inside has four control states: `C_RESET`, `C_RUN`, `C_PAUSE` and `C_ARMED`. `C_ARMED` is a paused state that remembers one pending leave-pause command.

The transitions are as follows:
- reset-to-run, run-to-reset, reset-to-pause and run-to-pause are taken on state writes of 01 and 11 (and 00 toward reset).
- pause-to-armed is taken on a first write of code 10.
- armed-to-reset is taken on a second consecutive write of code 10.
- armed-to-pause (disarm) is taken on a write of 00 while armed.
- pause-or-armed-to-run and pause-or-armed-to-pause are taken on writes of 01 or 11.
- any state goes to reset on a soft-reset command.

Top module: `prsc_top`

## Requirements
- R1: After hardware reset the state reads RESET with valid set, every flag, status and enable field reads 0, and all outputs are low.
- R2: Register 0 reads the state code in bits 1:0 (RESET=00, RUN=01, PAUSE=11) and valid in bit 2. While valid is set, a write to register 0 of 01 selects RUN, 11 selects PAUSE, and 00 selects RESET from RESET or RUN.
- R3: After every accepted state change, valid is low for exactly SETTLE_CYC (2) cycles and then returns high.
- R4: A write to register 0 while valid is low has no effect on the state.
- R5: From PAUSE, the state reaches RESET only after two consecutive register-0 writes of 10. The first write leaves the state in PAUSE with valid still high. A write of 00 in PAUSE, or any other state write in between, cancels the pending first write. A write of 10 outside PAUSE is ignored.
- R6: Writing 1 in bit 0 of register 1 forces RESET at once, whatever the state and valid, and starts a new settle window. Writing 0 there does nothing. Register 1 reads 0.
- R7: `run_en` is high exactly when the state is RUN and valid is set.
- R8: Every entry into RESET (by soft reset, by a write of 00, or by the double 10 write) clears the error flags, master status and both service flags. The error enable register keeps its value.
- R9: Register 5 holds master status in bits 24:2, set by `mst_evt` (bit k of the input sets bit k+2) and cleared by writing 1. Bits 31:25 and 1:0 read 0.
- R10: Register 3 holds error flags in bits 6:2, set by `err_evt` (bit k sets bit k+2) and cleared by writing 1. Register 4 holds read/write enables in bits 6:2. `err_irq` is high when any flag has its enable set.
- R11: The output service flag (register 2 bit 0, and `out_svc`) is set in the cycle after `ofifo_not_empty` is sampled going from 1 to 0. Writing 1 to that bit clears it.
- R12: The input service flag (register 2 bit 1, and `in_svc`) is set in the cycle after `ififo_avail` is sampled rising. Writing 1 to that bit clears it.
- R13: When a set event and a write-one clear hit the same bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`; unmapped addresses read 0 |
| err_evt | input | ERR_HI-ERR_LO+1 (5) | Error event pulses from the protocol engine |
| mst_evt | input | MST_HI-MST_LO+1 (23) | Master status event pulses |
| ofifo_not_empty | input | 1 | Output FIFO holds data |
| ififo_avail | input | 1 | Input FIFO has data available |
| run_en | output | 1 | Engine may run |
| out_svc | output | 1 | Output service flag |
| in_svc | output | 1 | Input service flag |
| err_irq | output | 1 | An enabled error flag is set |

## Verification
The bench builds the block with its default parameters: a 2-cycle settle window, a 32-bit data bus, a 3-bit address, error flags in bits 6:2 and master status in bits 24:2. The short settle window means back-to-back writes land inside it, which exercises the ignored-write and soft-reset-during-settle cases often. With a 3-bit address, the unmapped addresses 6 and 7 can also be reached. A behavioural model in the bench predicts every output and the read data on every cycle. It is driven first by directed sequences for the pause-to-reset pairing, same-cycle set and clear, and edge-triggered flags, and then by a long random mix of writes, events and FIFO levels.

// File: rtl/prsc_pkg.sv
package prsc_pkg;

    // Externally visible state codes (register 0, bits 1:0)
    typedef enum logic [1:0] {
        RS_RESET = 2'b00,
        RS_RUN   = 2'b01,
        RS_PAUSE = 2'b11
    } run_state_e;

    // Internal control states; C_ARMED is PAUSE with one leave command pending
    typedef enum logic [1:0] {
        C_RESET = 2'b00,
        C_RUN   = 2'b01,
        C_PAUSE = 2'b10,
        C_ARMED = 2'b11
    } ctl_state_e;

    localparam logic [1:0] CODE_RESET = 2'b00;
    localparam logic [1:0] CODE_RUN   = 2'b01;
    localparam logic [1:0] CODE_LEAVE = 2'b10;
    localparam logic [1:0] CODE_PAUSE = 2'b11;

    // Register map
    localparam int A_STATE   = 0;
    localparam int A_SOFTRST = 1;
    localparam int A_SVC     = 2;
    localparam int A_ERR     = 3;
    localparam int A_ERR_EN  = 4;
    localparam int A_MSTAT   = 5;

endpackage

// File: rtl/prsc_state_ctl.sv
module prsc_state_ctl
    import prsc_pkg::*;
#(
    parameter int SETTLE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_state,
    input  logic [1:0] wr_code,
    input  logic       soft_rst,
    output run_state_e state_o,
    output logic       valid_o,
    output logic       enter_reset_o
);

    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

    ctl_state_e       ctl_q, ctl_d;
    logic [CNT_W-1:0] settle_q;
    logic             load_settle;
    logic             enter_rst;

    assign valid_o       = (settle_q == '0);
    assign enter_reset_o = enter_rst;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= C_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Settle counter: valid is low while it is non-zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (load_settle) begin
            settle_q <= CNT_W'(SETTLE_CYC);
        end else if (settle_q != '0) begin
            settle_q <= settle_q - CNT_W'(1);
        end
    end

    // Next-state logic
    always_comb begin
        ctl_d       = ctl_q;
        load_settle = 1'b0;
        enter_rst   = 1'b0;
        if (soft_rst) begin
            ctl_d       = C_RESET;
            load_settle = 1'b1;
            enter_rst   = 1'b1;
        end else if (wr_state && valid_o) begin
            unique case (ctl_q)
                C_RESET, C_RUN: begin
                    unique case (wr_code)
                        CODE_RESET: begin
                            ctl_d       = C_RESET;
                            load_settle = 1'b1;
                            enter_rst   = 1'b1;
                        end
                        CODE_RUN: begin
                            ctl_d       = C_RUN;
                            load_settle = 1'b1;
                        end
                        CODE_PAUSE: begin
                            ctl_d       = C_PAUSE;
                            load_settle = 1'b1;
                        end
                        default: ctl_d = ctl_q;
                    endcase
                end
                C_PAUSE: begin
                    unique case (wr_code)
                        CODE_RUN: begin
                            ctl_d       = C_RUN;
                            load_settle = 1'b1;
                        end
                        CODE_PAUSE: begin
                            ctl_d       = C_PAUSE;
                            load_settle = 1'b1;
                        end
                        CODE_LEAVE: ctl_d = C_ARMED;
                        default:    ctl_d = C_PAUSE;
                    endcase
                end
                C_ARMED: begin
                    unique case (wr_code)
                        CODE_LEAVE: begin
                            ctl_d       = C_RESET;
                            load_settle = 1'b1;
                            enter_rst   = 1'b1;
                        end
                        CODE_RUN: begin
                            ctl_d       = C_RUN;
                            load_settle = 1'b1;
                        end
                        CODE_PAUSE: begin
                            ctl_d       = C_PAUSE;
                            load_settle = 1'b1;
                        end
                        default: ctl_d = C_PAUSE;
                    endcase
                end
                default: ctl_d = C_RESET;
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (ctl_q)
            C_RESET: state_o = RS_RESET;
            C_RUN:   state_o = RS_RUN;
            C_PAUSE: state_o = RS_PAUSE;
            C_ARMED: state_o = RS_PAUSE;
            default: state_o = RS_RESET;
        endcase
    end

    // R3: once valid falls it stays low for at least the next cycle
    a_r3_settle_min: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && $past(valid_o)) |=> !valid_o);

    // R3: valid only returns after two low cycles
    a_r3_settle_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> !$past(valid_o, 2));

    // R4: state writes while settling leave the state alone
    a_r4_ignore_unsettled: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state && !valid_o && !soft_rst) |=> $stable(state_o));

    // R5: a first leave command in PAUSE keeps PAUSE and valid
    a_r5_first_leave_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q == C_PAUSE && wr_state && wr_code == CODE_LEAVE && valid_o && !soft_rst)
        |=> (state_o == RS_PAUSE && valid_o));

    // R6: soft reset always lands in RESET with valid low
    a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state_o == RS_RESET && !valid_o));

endmodule

// File: rtl/prsc_w1c_bank.sv
module prsc_w1c_bank #(
    parameter int WIDTH = 32,
    parameter int LO    = 2,
    parameter int HI    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i >= LO && i <= HI) begin : g_live
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (flush) begin
                    bit_q <= 1'b0;
                end else begin
                    // set has priority over a same-cycle clear
                    bit_q <= set_vec[i] | (bit_q & ~clr_vec[i]);
                end
            end
            assign q[i] = bit_q;
        end else begin : g_rsvd
            logic unused_pair;
            assign unused_pair = set_vec[i] ^ clr_vec[i];
            assign q[i]        = 1'b0;
        end
    end

endmodule

// File: rtl/prsc_svc_flags.sv
module prsc_svc_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       ofifo_ne,
    input  logic       in_avail,
    input  logic [1:0] clr,
    output logic       out_flag,
    output logic       in_flag
);

    logic ofifo_prev, iav_prev;
    logic out_q, in_q;
    logic ofifo_fall, iav_rise;

    assign ofifo_fall = ofifo_prev & ~ofifo_ne;
    assign iav_rise   = in_avail & ~iav_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofifo_prev <= 1'b0;
            iav_prev   <= 1'b0;
        end else begin
            ofifo_prev <= ofifo_ne;
            iav_prev   <= in_avail;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            in_q  <= 1'b0;
        end else if (flush) begin
            out_q <= 1'b0;
            in_q  <= 1'b0;
        end else begin
            out_q <= ofifo_fall | (out_q & ~clr[0]);
            in_q  <= iav_rise | (in_q & ~clr[1]);
        end
    end

    assign out_flag = out_q;
    assign in_flag  = in_q;

    // R11: a sampled fall of the output FIFO level raises the flag
    a_r11_out_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ofifo_ne) && !flush) |=> out_flag);

    // R12: a sampled rise of input availability raises the flag
    a_r12_in_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_avail) && !flush) |=> in_flag);

endmodule

// File: rtl/prsc_top.sv
module prsc_top
    import prsc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int SETTLE_CYC = 2,
    parameter int ERR_LO     = 2,
    parameter int ERR_HI     = 6,
    parameter int MST_LO     = 2,
    parameter int MST_HI     = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [ERR_HI-ERR_LO:0] err_evt,
    input  logic [MST_HI-MST_LO:0] mst_evt,
    input  logic                 ofifo_not_empty,
    input  logic                 ififo_avail,
    output logic                 run_en,
    output logic                 out_svc,
    output logic                 in_svc,
    output logic                 err_irq
);

    localparam logic [DATA_W-1:0] ERR_MASK =
        (DATA_W'(1) << (ERR_HI + 1)) - (DATA_W'(1) << ERR_LO);

    run_state_e        state;
    logic              valid;
    logic              enter_rst;
    logic              wr_state, wr_soft;
    logic [DATA_W-1:0] err_set, err_clr, err_q;
    logic [DATA_W-1:0] mst_set, mst_clr, mst_q;
    logic [DATA_W-1:0] err_en_q;
    logic [1:0]        svc_clr;

    // Write decode
    assign wr_state = reg_wr && (reg_addr == ADDR_W'(A_STATE));
    assign wr_soft  = reg_wr && (reg_addr == ADDR_W'(A_SOFTRST)) && reg_wdata[0];
    assign err_clr  = (reg_wr && reg_addr == ADDR_W'(A_ERR))   ? reg_wdata : '0;
    assign mst_clr  = (reg_wr && reg_addr == ADDR_W'(A_MSTAT)) ? reg_wdata : '0;
    assign svc_clr  = (reg_wr && reg_addr == ADDR_W'(A_SVC))   ? reg_wdata[1:0] : 2'b00;
    assign err_set  = DATA_W'(err_evt) << ERR_LO;
    assign mst_set  = DATA_W'(mst_evt) << MST_LO;

    prsc_state_ctl #(
        .SETTLE_CYC (SETTLE_CYC)
    ) i_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_state      (wr_state),
        .wr_code       (reg_wdata[1:0]),
        .soft_rst      (wr_soft),
        .state_o       (state),
        .valid_o       (valid),
        .enter_reset_o (enter_rst)
    );

    prsc_w1c_bank #(
        .WIDTH (DATA_W),
        .LO    (ERR_LO),
        .HI    (ERR_HI)
    ) i_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (enter_rst),
        .set_vec (err_set),
        .clr_vec (err_clr),
        .q       (err_q)
    );

    prsc_w1c_bank #(
        .WIDTH (DATA_W),
        .LO    (MST_LO),
        .HI    (MST_HI)
    ) i_mst (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (enter_rst),
        .set_vec (mst_set),
        .clr_vec (mst_clr),
        .q       (mst_q)
    );

    prsc_svc_flags i_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (enter_rst),
        .ofifo_ne (ofifo_not_empty),
        .in_avail (ififo_avail),
        .clr      (svc_clr),
        .out_flag (out_svc),
        .in_flag  (in_svc)
    );

    // Error enable register (plain read/write, survives entry to RESET)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_en_q <= '0;
        end else if (reg_wr && reg_addr == ADDR_W'(A_ERR_EN)) begin
            err_en_q <= reg_wdata & ERR_MASK;
        end
    end

    // Read mux
    always_comb begin
        case (reg_addr)
            ADDR_W'(A_STATE):  reg_rdata = DATA_W'({valid, state});
            ADDR_W'(A_SVC):    reg_rdata = DATA_W'({in_svc, out_svc});
            ADDR_W'(A_ERR):    reg_rdata = err_q;
            ADDR_W'(A_ERR_EN): reg_rdata = err_en_q;
            ADDR_W'(A_MSTAT):  reg_rdata = mst_q;
            default:           reg_rdata = '0;
        endcase
    end

    assign run_en  = (state == RS_RUN) && valid;
    assign err_irq = |(err_q & err_en_q);

    // R7: the engine never runs outside a settled RUN state
    a_r7_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> (reg_wr || 1'b1) && valid && state == RS_RUN);

    // R8: entry into RESET leaves every sticky status cleared
    a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        enter_rst |=> (err_q == '0 && mst_q == '0 && !out_svc && !in_svc));

    // R9: reserved status bits never read as one
    a_r9_mst_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_q[1:0] == 2'b00 && mst_q[DATA_W-1:MST_HI+1] == '0));

    // R13: a set event wins over a same-cycle write-one clear
    a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set[ERR_LO] && err_clr[ERR_LO] && !enter_rst) |=> err_q[ERR_LO]);

endmodule

// File: tb/test_prsc_top.sv
module test_prsc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  err_evt = '0;
    logic [22:0] mst_evt = '0;
    logic        ofifo_not_empty = 1'b0;
    logic        ififo_avail = 1'b0;
    logic        run_en, out_svc, in_svc, err_irq;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    prsc_top i_prsc_top (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr          (reg_wr),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .err_evt         (err_evt),
        .mst_evt         (mst_evt),
        .ofifo_not_empty (ofifo_not_empty),
        .ififo_avail     (ififo_avail),
        .run_en          (run_en),
        .out_svc         (out_svc),
        .in_svc          (in_svc),
        .err_irq         (err_irq)
    );

    // ---------------- behavioural reference model ----------------
    int          m_st = 0;       // 0 reset, 1 run, 3 pause
    int          m_cnt = 0;      // settle cycles left
    bit          m_arm = 0;
    logic [31:0] m_err = 0, m_en = 0, m_mst = 0;
    bit          m_osvc = 0, m_isvc = 0, m_oprev = 0, m_iprev = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_arm = 0;
            m_err = 0; m_en = 0; m_mst = 0;
            m_osvc = 0; m_isvc = 0; m_oprev = 0; m_iprev = 0;
        end else begin
            bit entr;
            bit ofall, irise;
            entr  = 0;
            ofall = m_oprev && !ofifo_not_empty;
            irise = ififo_avail && !m_iprev;
            if (reg_wr && reg_addr == 1 && reg_wdata[0]) begin
                m_st = 0; m_cnt = 2; m_arm = 0; entr = 1;
            end else if (reg_wr && reg_addr == 0 && m_cnt == 0) begin
                int code;
                code = int'(reg_wdata[1:0]);
                if (m_st == 3 && code == 2) begin
                    if (m_arm) begin m_st = 0; m_cnt = 2; m_arm = 0; entr = 1; end
                    else m_arm = 1;
                end else begin
                    m_arm = 0;
                    if (code == 2) begin end
                    else if (m_st == 3 && code == 0) begin end
                    else begin m_st = code; m_cnt = 2; entr = (code == 0); end
                end
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
            end
            if (entr) begin
                m_err = 0; m_mst = 0; m_osvc = 0; m_isvc = 0;
            end else begin
                m_err = (({27'd0, err_evt} << 2) |
                         (m_err & ~((reg_wr && reg_addr == 3) ? reg_wdata : 32'd0))) & 32'h7C;
                m_mst = (({9'd0, mst_evt} << 2) |
                         (m_mst & ~((reg_wr && reg_addr == 5) ? reg_wdata : 32'd0))) & 32'h01FF_FFFC;
                m_osvc = ofall || (m_osvc && !(reg_wr && reg_addr == 2 && reg_wdata[0]));
                m_isvc = irise || (m_isvc && !(reg_wr && reg_addr == 2 && reg_wdata[1]));
            end
            if (reg_wr && reg_addr == 4) m_en = reg_wdata & 32'h7C;
            m_oprev = ofifo_not_empty;
            m_iprev = ififo_avail;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {29'd0, (m_cnt == 0), 2'(m_st)};
            3'd2: return {30'd0, m_isvc, m_osvc};
            3'd3: return m_err;
            3'd4: return m_en;
            3'd5: return m_mst;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R3";
            3'd2: return "R11";
            3'd3: return "R10";
            3'd4: return "R10";
            3'd5: return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one cycle: wait for the falling edge, compare everything
    task automatic tick();
        @(negedge clk);
        chk("R7",  "run_en",  {31'd0, run_en},  {31'd0, (m_st == 1 && m_cnt == 0)});
        chk("R11", "out_svc", {31'd0, out_svc}, {31'd0, m_osvc});
        chk("R12", "in_svc",  {31'd0, in_svc},  {31'd0, m_isvc});
        chk("R10", "err_irq", {31'd0, err_irq}, {31'd0, |(m_err & m_en)});
        chk(rd_tag(reg_addr), "rdata", reg_rdata, exp_rd(reg_addr));
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic peek(input int a, input int n);
        reg_addr = 3'(a);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic run_state_check(input int code, input string tag);
        reg_addr = 3'd0;
        vectors++;
        if (reg_rdata[1:0] !== 2'(code)) begin
            fails++;
            $display("FAIL %s state: actual %0d expected %0d", tag, reg_rdata[1:0], code);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) peek(a, 1);

        // R2, R3, R7: RESET -> RUN, settle window
        wr(0, 32'h1);
        peek(0, 4);
        run_state_check(1, "R2");

        // R4: second write lands while unsettled and is ignored
        wr(0, 32'h0);
        wr(0, 32'h3);
        peek(0, 3);
        run_state_check(0, "R4");
        wr(0, 32'h3);
        peek(0, 3);
        run_state_check(3, "R2");

        // R5: single leave write keeps PAUSE; second completes it
        wr(0, 32'h2);
        peek(0, 2);
        run_state_check(3, "R5");
        wr(0, 32'h2);
        peek(0, 3);
        run_state_check(0, "R5");
        // R5: interrupted pairing and 00 in PAUSE
        wr(0, 32'h3); peek(0, 3);
        wr(0, 32'h2); wr(0, 32'h0); wr(0, 32'h2);
        peek(0, 2);
        run_state_check(3, "R5");
        wr(0, 32'h1); peek(0, 3);
        wr(0, 32'h2); peek(0, 2);       // 10 outside PAUSE ignored
        run_state_check(1, "R5");

        // R9, R10, R13: status fields
        wr(4, 32'hFFFF_FFFF);
        err_evt = 5'b00101; mst_evt = 23'h40_0001;
        tick();
        err_evt = '0; mst_evt = '0;
        peek(3, 1); peek(5, 1);
        wr(3, 32'h04);
        wr(5, 32'h0100_0000);
        err_evt = 5'b10000;
        wr(3, 32'h40);                  // R13: set and clear together
        err_evt = '0;
        peek(3, 1);
        wr(4, 32'h0);
        peek(3, 1);
        wr(4, 32'h40);

        // R11, R12: service flags
        ofifo_not_empty = 1'b1; peek(2, 3);
        ofifo_not_empty = 1'b0; peek(2, 2);
        wr(2, 32'h1); peek(2, 1);
        ififo_avail = 1'b1; peek(2, 2);
        wr(2, 32'h2); peek(2, 2);       // level still high: no re-set
        ififo_avail = 1'b0; peek(2, 1);

        // R6, R8: soft reset clears status, keeps enables
        err_evt = 5'b11111; ififo_avail = 1'b1; tick();
        err_evt = '0; ififo_avail = 1'b0;
        wr(1, 32'h0);                   // bit 0 clear: no effect
        peek(0, 1);
        wr(1, 32'h1);
        peek(3, 1); peek(2, 1); peek(4, 1);
        wr(1, 32'h1);                   // during settle
        peek(0, 3);
        run_state_check(0, "R6");

        // R8: double-leave entry into RESET clears status
        wr(0, 32'h3); peek(0, 3);
        mst_evt = 23'h7F_FFFF; tick(); mst_evt = '0;
        wr(0, 32'h2); wr(0, 32'h2);
        peek(5, 2);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int a;
            logic [31:0] d;
            a = int'($urandom % 7);
            d = $urandom;
            if (a == 1) d[0] = (($urandom % 10) == 0);
            reg_wr = (($urandom % 3) == 0);
            reg_addr = 3'(a);
            reg_wdata = d;
            err_evt = (($urandom % 5) == 0) ? 5'($urandom) : 5'd0;
            mst_evt = (($urandom % 5) == 0) ? 23'($urandom) : 23'd0;
            ofifo_not_empty = (($urandom % 3) != 0);
            ififo_avail = (($urandom % 2) == 0);
            tick();
        end
        reg_wr = 1'b0;
        peek(0, 3);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule